// File: doc/BRIEF.md
# Software trace stimulus port unit

This block is a memory-mapped source of software trace. Firmware stores a 32-bit word into one of 32 stimulus port registers. If the unit is switched on, the addressed port is enabled and the group of eight ports that contains it is unmasked, the word is turned into a trace record. The record holds the port number, the data word and the 7-bit source identifier currently programmed in the control register. Records wait in a small queue and leave on a valid/ready output toward a downstream trace formatter.

Configuration is guarded by a key lock. The control, port-enable and group-mask registers accept writes only after the unlock key has been written to the lock register. The register interface is a single-cycle bus: a write is taken on the clock edge where select and write are high, and read data is a combinational function of the address. Timestamp and synchronisation fields in the control register are kept and read back, and they have no other effect.

Top module: `trace_stim_unit`

## Requirements
- R1: After reset the unit is locked, every control, port-enable and group-mask bit is zero, the drop counter is zero and `rec_valid` is low.
- R2: Writing 0xC5ACCE55 to offset 0xFB0 unlocks the unit, and writing any other value there locks it. While locked, writes to 0xE80, 0xE00 and 0xE40 change nothing. Offset 0xFB0 reads as zero.
- R3: The control register at 0xE80 reads back bit 0 global enable, bit 1 timestamp enable, bit 2 sync enable, bit 3 watchpoint stimulus enable, bit 4 timestamp clock select, bits 9:8 prescaler and bits 22:16 source ID. Bits 31:24, 15:10 and 7:5 read as zero.
- R4: The port-enable register at 0xE00 holds one bit per port (bit n is port n). The group-mask register at 0xE40 holds bits 3:0, where bit g unmasks ports 8g to 8g+7. Its bits 31:4 read as zero.
- R5: A write to offset 4n (n = 0..31) is a stimulus write to port n. It yields a record {port n, written word, current source ID} only when global enable, port-enable bit n and group-mask bit n/8 are all set. Otherwise it is discarded.
- R6: Records leave in write order, each visible on the output in the cycle after its write. A record holds its fields stable while `rec_valid` is high and `rec_ready` is low.
- R7: The queue holds 4 records. A qualifying stimulus write that finds it full is dropped and increments a drop counter that saturates at 255 and reads at offset 0xE84 bits 7:0.
- R8: Control bit 23 (busy) reads 1 exactly when a record is pending on the output.
- R9: Reading any stimulus port offset returns bit 0 = 1 when the queue has room and 0 when it is full. All other bits read as zero.
- R10: Fullness is judged before any handshake in the same cycle. A stimulus write arriving at a full queue in the cycle of an output handshake is dropped and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Downstream accepts record |
| rec_port | output | 5 | Port number of record |
| rec_srcid | output | 7 | Source identifier of record |
| rec_data | output | 32 | Traced word |

## Verification
Two events collide when a stimulus write reaches a full queue in the same cycle that the output handshake frees an entry. The bench provokes this by filling the queue with `rec_ready` low, then raising `rec_ready` in exactly the cycle of one more write. The behavioural model checks fullness before it pops, so the write must be lost, the drop counter must rise by one, and only the four earlier records may come out afterwards, in order. A second overlap is a push into an empty queue while the downstream is ready. The model compares each output cycle, so a record that skipped a cycle or arrived late would be reported.

// File: rtl/tsu_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the trace stimulus unit.
// Assumes a 12-bit byte offset bus; offsets are fixed by the register map.
package tsu_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
    localparam logic [11:0] OFF_LOCK   = 12'hFB0;
    localparam logic [11:0] OFF_CTRL   = 12'hE80;
    localparam logic [11:0] OFF_DROP   = 12'hE84;
    localparam logic [11:0] OFF_PEN    = 12'hE00;
    localparam logic [11:0] OFF_GMASK  = 12'hE40;
    localparam int          SRCID_W    = 7;

    // Stored control fields; busy is derived, not stored.
    typedef struct packed {
        logic [SRCID_W-1:0] srcid;
        logic [1:0]         prescale;
        logic               ts_clk_sel;
        logic               wpt_en;
        logic               sync_en;
        logic               ts_en;
        logic               glb_en;
    } ctrl_t;
endpackage

// File: rtl/tsu_regs.sv
`timescale 1ns/1ps
// Module: tsu_regs
// Holds the key lock, control fields, port enables, group masks and the
// saturating drop counter. Assumes wr_en is a one-cycle write strobe with
// a stable address. Lock reset state is "locked".
module tsu_regs
    import tsu_pkg::*;
#(
    parameter int NPORTS = 32,
    parameter int GROUP  = 8,
    parameter int AW     = 12,
    parameter int DROP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [31:0]              wdata,
    input  logic                     drop_inc,
    output logic                     locked,
    output ctrl_t                    ctrl,
    output logic [NPORTS-1:0]        port_en,
    output logic [NPORTS/GROUP-1:0]  gmask,
    output logic [DROP_W-1:0]        drop_cnt
);
    localparam int NGROUPS = NPORTS / GROUP;

    logic cfg_ok;
    assign cfg_ok = wr_en && !locked;

    // Lock: key unlocks, any other value written to the lock offset relocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (wr_en && addr == OFF_LOCK)
            locked <= (wdata != UNLOCK_KEY);
    end

    // Control fields: writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (cfg_ok && addr == OFF_CTRL) begin
            ctrl.srcid      <= wdata[22:16];
            ctrl.prescale   <= wdata[9:8];
            ctrl.ts_clk_sel <= wdata[4];
            ctrl.wpt_en     <= wdata[3];
            ctrl.sync_en    <= wdata[2];
            ctrl.ts_en      <= wdata[1];
            ctrl.glb_en     <= wdata[0];
        end
    end

    // Port enables: one bit per stimulus port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            port_en <= '0;
        else if (cfg_ok && addr == OFF_PEN)
            port_en <= wdata[NPORTS-1:0];
    end

    // Group masks: one bit per group of GROUP ports.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gmask <= '0;
        else if (cfg_ok && addr == OFF_GMASK)
            gmask <= wdata[NGROUPS-1:0];
    end

    // Drop counter: counts writes lost to a full queue, sticks at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_cnt <= '0;
        else if (drop_inc && drop_cnt != {DROP_W{1'b1}})
            drop_cnt <= drop_cnt + 1'b1;
    end
endmodule

// File: rtl/tsu_gate.sv
`timescale 1ns/1ps
// Module: tsu_gate
// Decodes stimulus port offsets and qualifies a stimulus write with the
// global enable, the port enable and the port's group mask. Purely
// combinational. Assumes NPORTS is a power of two and a multiple of GROUP.
module tsu_gate #(
    parameter int NPORTS = 32,
    parameter int GROUP  = 8,
    parameter int AW     = 12
) (
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic                          glb_en,
    input  logic [NPORTS-1:0]             port_en,
    input  logic [NPORTS/GROUP-1:0]       gmask,
    output logic                          stim_hit,
    output logic [$clog2(NPORTS)-1:0]     port_idx,
    output logic                          push_req
);
    localparam int PORT_W = $clog2(NPORTS);
    localparam int HI     = PORT_W + 2;

    logic [NPORTS-1:0] port_ok;

    // Per-port permission: port enable masked by its group bit.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign port_ok[p] = port_en[p] & gmask[p / GROUP];
    end

    // Offset decode and final qualification.
    always_comb begin
        stim_hit = (addr[AW-1:HI] == '0) && (addr[1:0] == 2'b00);
        port_idx = addr[HI-1:2];
        push_req = wr_en && stim_hit && glb_en && port_ok[port_idx];
    end
endmodule

// File: rtl/tsu_fifo.sv
`timescale 1ns/1ps
// Module: tsu_fifo
// Small circular record queue with an occupancy count. Assumes the caller
// never pushes when full nor pops when empty. Head entry drives dout.
module tsu_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 44
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Storage write: no reset needed, entries are qualified by count.
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Status flags and head data.
    always_comb begin
        empty = (count == '0);
        full  = (count == ($clog2(DEPTH+1))'(DEPTH));
        dout  = mem[rd_ptr];
    end
endmodule

// File: rtl/trace_stim_unit.sv
`timescale 1ns/1ps
// Module: trace_stim_unit (top)
// Software trace source: qualified stimulus writes become records
// {port, source ID, data} queued toward a valid/ready output. Assumes a
// single-cycle register bus; reads are combinational on bus_addr.
module trace_stim_unit
    import tsu_pkg::*;
#(
    parameter int NPORTS = 32,
    parameter int GROUP  = 8,
    parameter int DEPTH  = 4,
    parameter int DROP_W = 8,
    parameter int AW     = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       rec_valid,
    input  logic                       rec_ready,
    output logic [$clog2(NPORTS)-1:0]  rec_port,
    output logic [SRCID_W-1:0]         rec_srcid,
    output logic [31:0]                rec_data
);
    localparam int PORT_W  = $clog2(NPORTS);
    localparam int NGROUPS = NPORTS / GROUP;
    localparam int REC_W   = PORT_W + SRCID_W + 32;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    logic                 wr_en;
    logic                 locked;
    ctrl_t                ctrl_q;
    logic [NPORTS-1:0]    port_en;
    logic [NGROUPS-1:0]   gmask;
    logic [DROP_W-1:0]    drop_cnt;
    logic                 stim_hit;
    logic [PORT_W-1:0]    port_idx;
    logic                 push_req;
    logic                 fifo_full;
    logic                 fifo_empty;
    logic [CNT_W-1:0]     fifo_cnt;
    logic [REC_W-1:0]     head;
    logic                 push;
    logic                 pop;
    logic                 drop_inc;

    assign wr_en = bus_sel && bus_wr;

    tsu_regs #(
        .NPORTS(NPORTS), .GROUP(GROUP), .AW(AW), .DROP_W(DROP_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .drop_inc(drop_inc), .locked(locked),
        .ctrl(ctrl_q), .port_en(port_en), .gmask(gmask), .drop_cnt(drop_cnt)
    );

    tsu_gate #(
        .NPORTS(NPORTS), .GROUP(GROUP), .AW(AW)
    ) u_gate (
        .wr_en(wr_en), .addr(bus_addr), .glb_en(ctrl_q.glb_en),
        .port_en(port_en), .gmask(gmask), .stim_hit(stim_hit),
        .port_idx(port_idx), .push_req(push_req)
    );

    // Queue admission: fullness is taken before any same-cycle pop.
    always_comb begin
        push     = push_req && !fifo_full;
        drop_inc = push_req && fifo_full;
        pop      = !fifo_empty && rec_ready;
    end

    tsu_fifo #(
        .DEPTH(DEPTH), .WIDTH(REC_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push),
        .din({port_idx, ctrl_q.srcid, bus_wdata}), .pop(pop),
        .dout(head), .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
    );

    // Output record fields from the queue head.
    always_comb begin
        rec_valid = !fifo_empty;
        {rec_port, rec_srcid, rec_data} = head;
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        if (stim_hit)
            bus_rdata[0] = !fifo_full;
        else begin
            case (bus_addr)
                OFF_CTRL:  bus_rdata = {8'b0, !fifo_empty, ctrl_q.srcid, 6'b0,
                                        ctrl_q.prescale, 3'b0, ctrl_q.ts_clk_sel,
                                        ctrl_q.wpt_en, ctrl_q.sync_en,
                                        ctrl_q.ts_en, ctrl_q.glb_en};
                OFF_DROP:  bus_rdata[DROP_W-1:0]  = drop_cnt;
                OFF_PEN:   bus_rdata[NPORTS-1:0]  = port_en;
                OFF_GMASK: bus_rdata[NGROUPS-1:0] = gmask;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tsu_checker.sv
`timescale 1ns/1ps
// Module: tsu_checker
// Temporal checks on the trace stimulus unit, bound into the top.
// Assumes synchronous active-low reset held from time zero.
module tsu_checker
    import tsu_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DROP_W = 8,
    parameter int AW     = 12,
    parameter int PORT_W = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [AW-1:0]               bus_addr,
    input logic                        locked,
    input ctrl_t                       ctrl,
    input logic                        rec_valid,
    input logic                        rec_ready,
    input logic [PORT_W-1:0]           rec_port,
    input logic [31:0]                 rec_data,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_cnt,
    input logic [DROP_W-1:0]           drop_cnt
);
    // R1: reset leaves the unit locked, empty, with a clear drop counter.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (locked && drop_cnt == '0 && !rec_valid));

    // R2: a control write while locked leaves the control fields untouched.
    assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_sel && bus_wr && bus_addr == OFF_CTRL) |=> $stable(ctrl));

    // R6: a stalled record keeps its fields.
    assert_hold_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_port)));

    // R7: drop counter never wraps once saturated.
    assert_drop_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == {DROP_W{1'b1}}) |=> (drop_cnt == {DROP_W{1'b1}}));

    // R7: drop counter moves by at most one per cycle and never falls.
    assert_drop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != {DROP_W{1'b1}}) |=>
        (drop_cnt == $past(drop_cnt) || drop_cnt == DROP_W'($past(drop_cnt) + 1'b1)));

    // R10: occupancy never exceeds the queue depth.
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind trace_stim_unit tsu_checker #(
    .DEPTH(DEPTH), .DROP_W(DROP_W), .AW(AW), .PORT_W($clog2(NPORTS))
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .locked(locked), .ctrl(ctrl_q),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_port(rec_port),
    .rec_data(rec_data), .fifo_cnt(fifo_cnt), .drop_cnt(drop_cnt)
);

// File: tb/sim_trace_stim_unit.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared against the unit every cycle,
// plus directed scenarios for lock, gating, overflow and collisions.
module sim_trace_stim_unit;
    localparam logic [31:0] KEY = 32'hC5AC_CE55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rec_valid;
    logic        rec_ready = 1'b1;
    logic [4:0]  rec_port;
    logic [6:0]  rec_srcid;
    logic [31:0] rec_data;

    int checks = 0;
    int errors = 0;
    int rec_seen = 0;

    always #2.5 clk = ~clk;

    trace_stim_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_port(rec_port),
        .rec_srcid(rec_srcid), .rec_data(rec_data)
    );

    // Reference model state
    typedef struct { logic [4:0] port; logic [6:0] sid; logic [31:0] data; } rec_t;
    rec_t        mq[$];
    logic        m_locked;
    logic [31:0] m_ctrl;
    logic [31:0] m_pen;
    logic [3:0]  m_gmask;
    int          m_drop;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic is_stim(input logic [11:0] a);
        return (a[11:7] == 5'd0) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (is_stim(a)) return {31'd0, mq.size() < 4};
        case (a)
            12'hE80: return m_ctrl | {8'd0, mq.size() > 0, 23'd0};
            12'hE84: return 32'(m_drop);
            12'hE00: return m_pen;
            12'hE40: return {28'd0, m_gmask};
            default: return 32'd0;
        endcase
    endfunction

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_locked = 1'b1; m_ctrl = '0; m_pen = '0; m_gmask = '0; m_drop = 0;
        end else begin
            automatic logic was_full = (mq.size() >= 4);
            automatic logic do_pop = (mq.size() > 0) && rec_ready;
            automatic rec_t nr;
            automatic logic do_push = 1'b0;
            if (do_pop) rec_seen++;
            if (bus_sel && bus_wr) begin
                if (bus_addr == 12'hFB0) m_locked = (bus_wdata != KEY);
                else if (bus_addr == 12'hE80 && !m_locked) m_ctrl = bus_wdata & 32'h007F_031F;
                else if (bus_addr == 12'hE00 && !m_locked) m_pen = bus_wdata;
                else if (bus_addr == 12'hE40 && !m_locked) m_gmask = bus_wdata[3:0];
                else if (is_stim(bus_addr)) begin
                    automatic int p = int'(bus_addr[6:2]);
                    if (m_ctrl[0] && m_pen[p] && m_gmask[p/8]) begin
                        if (was_full) begin
                            if (m_drop < 255) m_drop++;
                        end else begin
                            nr.port = bus_addr[6:2]; nr.sid = m_ctrl[22:16]; nr.data = bus_wdata;
                            do_push = 1'b1;
                        end
                    end
                end
            end
            if (do_pop) void'(mq.pop_front());
            if (do_push) mq.push_back(nr);
        end
    end

    // Per-cycle comparison, away from the rising edge
    always begin
        @(negedge clk); #1;
        if (rst_n) begin
            check("R6 rec_valid", {31'd0, rec_valid}, {31'd0, mq.size() > 0});
            if (mq.size() > 0 && rec_valid) begin
                check("R5 rec_port", {27'd0, rec_port}, {27'd0, mq[0].port});
                check("R5 rec_srcid", {25'd0, rec_srcid}, {25'd0, mq[0].sid});
                check("R6 rec_data order", rec_data, mq[0].data);
            end
            if (bus_sel && !bus_wr)
                check(is_stim(bus_addr) ? "R9 stim read" : "R3/R4 reg read",
                      bus_rdata, model_read(bus_addr));
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(12'hE80, rd); check("R1 ctrl after reset", rd, 32'h0);
        bus_read(12'hE00, rd); check("R1 port enable after reset", rd, 32'h0);
        bus_read(12'hE40, rd); check("R1 group mask after reset", rd, 32'h0);
        bus_read(12'hE84, rd); check("R1 drop count after reset", rd, 32'h0);
        check("R1 rec_valid after reset", {31'd0, rec_valid}, 32'h0);
        // R2 locked writes ignored
        bus_write(12'hE80, 32'h0001_0005);
        bus_write(12'hE00, 32'hFFFF_FFFF);
        bus_write(12'hE40, 32'hF);
        bus_read(12'hE80, rd); check("R2 locked ctrl write", rd, 32'h0);
        bus_read(12'hE00, rd); check("R2 locked enable write", rd, 32'h0);
        bus_read(12'hE40, rd); check("R2 locked mask write", rd, 32'h0);
        // R2 unlock, R3 field layout
        bus_write(12'hFB0, KEY);
        bus_read(12'hFB0, rd); check("R2 lock reads zero", rd, 32'h0);
        bus_write(12'hE80, 32'hFFFF_FFFF);
        bus_read(12'hE80, rd); check("R3 ctrl reserved bits", rd, 32'h007F_031F);
        bus_write(12'hE80, 32'h0025_0001);
        // R4 enable and mask registers
        bus_write(12'hE00, 32'h8000_0101);
        bus_read(12'hE00, rd); check("R4 enable readback", rd, 32'h8000_0101);
        bus_write(12'hE40, 32'hFF);
        bus_read(12'hE40, rd); check("R4 mask upper bits", rd, 32'hF);
        bus_write(12'hE40, 32'h5);
        // R5 gating
        base = rec_seen;
        bus_write(12'h020, 32'hBAD0_0008);  // port 8: group 1 masked
        bus_write(12'h004, 32'hBAD0_0001);  // port 1: not enabled
        bus_write(12'h07C, 32'hBAD0_001F);  // port 31: group 3 masked
        idle(2);
        check("R5 gated writes discarded", 32'(rec_seen - base), 32'd0);
        bus_write(12'h000, 32'hA0A0_0000);
        idle(2);
        check("R5 enabled port emits", 32'(rec_seen - base), 32'd1);
        bus_write(12'hE40, 32'hF);
        bus_write(12'h07C, 32'hA0A0_001F);
        idle(2);
        check("R5 port 31 after unmask", 32'(rec_seen - base), 32'd2);
        // R2 relock with non-key value
        bus_write(12'hFB0, 32'h0000_1234);
        bus_write(12'hE80, 32'h0);
        bus_write(12'hE00, 32'h0);
        bus_read(12'hE80, rd); check("R2 relocked ctrl", rd, 32'h0025_0001);
        bus_read(12'hE00, rd); check("R2 relocked enable", rd, 32'h8000_0101);
        bus_write(12'hFB0, KEY);
        // R7 full queue, R8 busy, R9 poll, R6 hold
        rec_ready = 1'b0;
        for (int i = 0; i < 6; i++) bus_write(12'h000, 32'h100 + 32'(i));
        bus_read(12'hE84, rd); check("R7 drops counted", rd, 32'd2);
        bus_read(12'h000, rd); check("R9 full poll", rd, 32'd0);
        bus_read(12'h07C, rd); check("R9 full poll port 31", rd, 32'd0);
        bus_read(12'hE80, rd); check("R8 busy set", rd, 32'h00A5_0001);
        check("R6 held head", rec_data, 32'h100);
        base = rec_seen;
        rec_ready = 1'b1;
        idle(6);
        check("R6 drained four", 32'(rec_seen - base), 32'd4);
        bus_read(12'hE80, rd); check("R8 busy clear", rd, 32'h0025_0001);
        bus_read(12'h000, rd); check("R9 room poll", rd, 32'd1);
        // R10 write into full queue during handshake
        rec_ready = 1'b0;
        for (int i = 0; i < 4; i++) bus_write(12'h000, 32'h200 + 32'(i));
        base = rec_seen;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'hDEAD_0010;
        rec_ready = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rec_ready = 1'b0;
        bus_read(12'hE84, rd); check("R10 collision write dropped", rd, 32'd3);
        rec_ready = 1'b1;
        idle(6);
        check("R10 only earlier records leave", 32'(rec_seen - base), 32'd4);
        // R7 saturation
        rec_ready = 1'b0;
        for (int i = 0; i < 4; i++) bus_write(12'h000, 32'h300 + 32'(i));
        for (int i = 0; i < 260; i++) bus_write(12'h000, 32'hFFFF_0000 + 32'(i));
        bus_read(12'hE84, rd); check("R7 drop counter saturates", rd, 32'd255);
        rec_ready = 1'b1;
        idle(6);
        // R5 global enable off
        bus_write(12'hE80, 32'h0025_0000);
        base = rec_seen;
        bus_write(12'h000, 32'h5555_5555);
        idle(2);
        check("R5 global disable discards", 32'(rec_seen - base), 32'd0);
        bus_read(12'hE80, rd); check("R8 idle after disable", rd, 32'h0025_0000);
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule